// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a bank of small control registers inside a workstation I/O controller. A processor reaches it over a simple synchronous register bus. The bus carries an address, a write strobe, a read strobe, write data and read data. Reads are combinational and return data in the same cycle as the read strobe. Writes take effect at the clock edge that samples the write strobe.

The bank holds the following registers:
- a configuration byte
- two auxiliary bytes
- a diagnostic byte
- a modem-control byte
- a 16-bit diagnostic LED register, which also drives an LED output bus
- a 32-bit system control register

Some writes are commands, not plain storage. They raise registered one-cycle requests for shutdown, system reset or CPU halt. These requests go to external controllers, which are outside this block.

A power-fail input passes through a synchroniser. It can then set a sticky status bit in the second auxiliary register, provided the interrupt enable in the configuration byte is set. The status bit and the enable together drive a level interrupt. Software clears the status with a write-one command bit.

Two resets act on the bank. The asynchronous power-on reset clears everything. A synchronous soft reset clears only the configuration, both auxiliary registers and modem control.

Top module: `aux_ctl_regs`

## Requirements
- R1: The bus address is 28 bits. The four plain byte registers are decoded on the address ANDed with 0xFFF0000, so address bits 15:0 are ignored:
  - configuration at 0x1800000
  - first auxiliary at 0x1900000
  - diagnostic at 0x1A00000
  - modem control at 0x1B00000
  
  A write stores data bits 7:0, and a read returns the stored byte zero-extended.
- R2: `irq_o` is high exactly when status bit 2 of the second auxiliary register and enable bit 3 of the configuration byte are both 1. Changing the configuration byte does not alter the stored status bit.
- R3: `pwr_fail` passes through a two-flop synchroniser. On every change of the synchronised level, status bit 2 becomes (level AND configuration bit 3). The new value is visible from the third rising edge after the input changes.
- R4: The second auxiliary register is at 0x1910000 (same mask as R1) and reads back as 3 bits, zero-extended. A write takes data bits 1:0 and keeps the current bit 2. If data bit 1 is 1, the stored value becomes {0,0,data bit 0}, which clears the power-fail status. Stored bit 1 is always 0.
- R5: A write to the second auxiliary register with data bit 0 set raises `shutdown_req` for exactly the one cycle that follows the write edge.
- R6: Any write to the power-management address 0xA000000 (same mask as R1) raises `halt_req` for exactly the one cycle that follows the write edge. A read of that address returns 0.
- R7: The system control register has a 4-byte window at 0x1F00000. Only the address with bits 1:0 equal to 0 is decoded.
  - A write there with data bit 0 set loads the register with 0x2 and raises `sysrst_req` for one cycle.
  - A write with data bit 0 clear is ignored.
  - Other offsets read 0, and writes to them do nothing.
- R8: The LED register has a 4-byte window at 0x1600000. Offset 0 stores data bits 15:0, drives `led_o` and reads back the stored value. Other offsets read 0.
- R9: A soft reset (`soft_rst` high at an edge) clears the configuration, first auxiliary, second auxiliary and modem-control registers. It leaves the diagnostic, system control and LED registers unchanged.
- R10: Power-on reset (`rst_n` low) clears every register, `led_o`, `irq_o`, all request outputs and the synchroniser.
- R11: `bus_rdata` is 0 while `bus_rd` is low, and 0 for any undecoded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous partial reset, active high |
| bus_addr | input | 28 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pwr_fail | input | 1 | Asynchronous power-fail indication |
| irq_o | output | 1 | Level power-fail interrupt |
| led_o | output | 16 | Diagnostic LED drive |
| shutdown_req | output | 1 | One-cycle shutdown request |
| sysrst_req | output | 1 | One-cycle system reset request |
| halt_req | output | 1 | One-cycle CPU halt request |

## Verification
The checker watches several rules on every cycle:
- each request pulse is tied to the write that caused it, in both directions
- stored auxiliary bit 1 never reads as 1
- after a clear command the interrupt is low
- after any soft reset the four soft-clearable registers read 0
- a reset request always coincides with the system control register holding 0x2

Other behaviour only the bench scenarios can show. These include byte storage and aliasing across the address sweep, the synchroniser latency, and the sticky status surviving a change of enable. They also include the registers that a soft reset must keep, and which offsets and addresses read as zero.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_AUX1,
    SEL_AUX2,
    SEL_DIAG,
    SEL_MCTL,
    SEL_PM,
    SEL_LED,
    SEL_SYS
  } sel_e;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned AUX2_W      = 3;
  localparam int unsigned IRQ_EN_BIT  = 3;
  localparam int unsigned PF_BIT      = 2;
  localparam int unsigned PF_CLR_BIT  = 1;
  localparam int unsigned OFF_BIT     = 0;
  localparam int unsigned SYS_CMD_BIT = 0;
  localparam int unsigned NUM_REQ     = 3;
  localparam int unsigned REQ_OFF     = 0;
  localparam int unsigned REQ_RST     = 1;
  localparam int unsigned REQ_HALT    = 2;

  // Second auxiliary register after a bus write: low bits from the bus,
  // status kept, and a clear command drops everything but bit 0.
  function automatic logic [AUX2_W-1:0] aux2_after_write(
    input logic [AUX2_W-1:0] cur,
    input logic [1:0]        wd
  );
    logic [AUX2_W-1:0] r;
    r = {cur[PF_BIT], wd};
    if (wd[PF_CLR_BIT]) r = {2'b00, wd[OFF_BIT]};
    return r;
  endfunction

  function automatic logic pf_status(input logic level, input logic enable);
    return level & enable;
  endfunction

endpackage

// File: rtl/aux_pf_sync.sv
module aux_pf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_o,
  output logic change_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign sync_o   = chain_q[STAGES-1];
  assign change_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/aux_addr_dec.sv
module aux_addr_dec
  import aux_ctl_pkg::*;
#(
  parameter int unsigned    AW        = 28,
  parameter logic [AW-1:0]  BYTE_MASK = 28'hFFF0000,
  parameter logic [AW-1:0]  CFG_BASE  = 28'h1800000,
  parameter logic [AW-1:0]  AUX1_BASE = 28'h1900000,
  parameter logic [AW-1:0]  AUX2_BASE = 28'h1910000,
  parameter logic [AW-1:0]  DIAG_BASE = 28'h1A00000,
  parameter logic [AW-1:0]  MCTL_BASE = 28'h1B00000,
  parameter logic [AW-1:0]  PM_BASE   = 28'hA000000,
  parameter logic [AW-1:0]  LED_BASE  = 28'h1600000,
  parameter logic [AW-1:0]  SYS_BASE  = 28'h1F00000
) (
  input  logic [AW-1:0] addr,
  output sel_e          sel
);
  localparam int unsigned WIN_BITS = 2;

  logic [AW-1:0] masked;
  logic          off_zero;

  assign masked   = addr & BYTE_MASK;
  assign off_zero = (addr[WIN_BITS-1:0] == '0);

  always_comb begin
    sel = SEL_NONE;
    if      (masked == (CFG_BASE  & BYTE_MASK)) sel = SEL_CFG;
    else if (masked == (AUX1_BASE & BYTE_MASK)) sel = SEL_AUX1;
    else if (masked == (AUX2_BASE & BYTE_MASK)) sel = SEL_AUX2;
    else if (masked == (DIAG_BASE & BYTE_MASK)) sel = SEL_DIAG;
    else if (masked == (MCTL_BASE & BYTE_MASK)) sel = SEL_MCTL;
    else if (masked == (PM_BASE   & BYTE_MASK)) sel = SEL_PM;
    else if (off_zero && addr[AW-1:WIN_BITS] == LED_BASE[AW-1:WIN_BITS]) sel = SEL_LED;
    else if (off_zero && addr[AW-1:WIN_BITS] == SYS_BASE[AW-1:WIN_BITS]) sel = SEL_SYS;
  end
endmodule

// File: rtl/aux_pulse_reg.sv
module aux_pulse_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_req
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= fire[i];
    end
  end
endmodule

// File: rtl/aux_ctl_regs.sv
module aux_ctl_regs
  import aux_ctl_pkg::*;
#(
  parameter int unsigned AW          = 28,
  parameter int unsigned DW          = 32,
  parameter int unsigned LED_W       = 16,
  parameter int unsigned SYS_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          pwr_fail,
  output logic          irq_o,
  output logic [LED_W-1:0] led_o,
  output logic          shutdown_req,
  output logic          sysrst_req,
  output logic          halt_req
);
  localparam logic [SYS_W-1:0] SYS_LOAD = SYS_W'(2);

  sel_e sel;
  logic pf_level, pf_change;
  logic [BYTE_W-1:0] cfg_q, aux1_q, diag_q, mctl_q;
  logic [AUX2_W-1:0] aux2_q, aux2_live;
  logic [LED_W-1:0]  led_q;
  logic [SYS_W-1:0]  sys_q;
  logic wr_cfg, wr_aux1, wr_aux2, wr_diag, wr_mctl, wr_pm, wr_led, wr_sys;
  logic [NUM_REQ-1:0] req_fire, req_pulse;

  aux_addr_dec #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  aux_pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pwr_fail),
    .sync_o   (pf_level),
    .change_o (pf_change)
  );

  assign wr_cfg  = bus_wr && (sel == SEL_CFG);
  assign wr_aux1 = bus_wr && (sel == SEL_AUX1);
  assign wr_aux2 = bus_wr && (sel == SEL_AUX2);
  assign wr_diag = bus_wr && (sel == SEL_DIAG);
  assign wr_mctl = bus_wr && (sel == SEL_MCTL);
  assign wr_pm   = bus_wr && (sel == SEL_PM);
  assign wr_led  = bus_wr && (sel == SEL_LED);
  assign wr_sys  = bus_wr && (sel == SEL_SYS);

  // Status bit refreshed on a synchronised power-fail edge, before any write.
  always_comb begin
    aux2_live = aux2_q;
    if (pf_change) aux2_live[PF_BIT] = pf_status(pf_level, cfg_q[IRQ_EN_BIT]);
  end

  // Soft-clearable group
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      aux1_q <= '0;
      aux2_q <= '0;
      mctl_q <= '0;
    end else if (soft_rst) begin
      cfg_q  <= '0;
      aux1_q <= '0;
      aux2_q <= '0;
      mctl_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= bus_wdata[BYTE_W-1:0];
      if (wr_aux1) aux1_q <= bus_wdata[BYTE_W-1:0];
      if (wr_mctl) mctl_q <= bus_wdata[BYTE_W-1:0];
      aux2_q <= wr_aux2 ? aux2_after_write(aux2_live, bus_wdata[1:0]) : aux2_live;
    end
  end

  // Group kept across soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_q <= '0;
      led_q  <= '0;
      sys_q  <= '0;
    end else begin
      if (wr_diag) diag_q <= bus_wdata[BYTE_W-1:0];
      if (wr_led)  led_q  <= bus_wdata[LED_W-1:0];
      if (wr_sys && bus_wdata[SYS_CMD_BIT]) sys_q <= SYS_LOAD;
    end
  end

  always_comb begin
    req_fire           = '0;
    req_fire[REQ_OFF]  = wr_aux2 && bus_wdata[OFF_BIT];
    req_fire[REQ_RST]  = wr_sys && bus_wdata[SYS_CMD_BIT];
    req_fire[REQ_HALT] = wr_pm;
  end

  aux_pulse_reg #(.N(NUM_REQ)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (req_fire),
    .pulse (req_pulse)
  );

  assign shutdown_req = req_pulse[REQ_OFF];
  assign sysrst_req   = req_pulse[REQ_RST];
  assign halt_req     = req_pulse[REQ_HALT];
  assign irq_o        = aux2_q[PF_BIT] & cfg_q[IRQ_EN_BIT];
  assign led_o        = led_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_CFG:  bus_rdata = DW'(cfg_q);
        SEL_AUX1: bus_rdata = DW'(aux1_q);
        SEL_AUX2: bus_rdata = DW'(aux2_q);
        SEL_DIAG: bus_rdata = DW'(diag_q);
        SEL_MCTL: bus_rdata = DW'(mctl_q);
        SEL_LED:  bus_rdata = DW'(led_q);
        SEL_SYS:  bus_rdata = DW'(sys_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  wire unused_wdata = ^bus_wdata[DW-1:LED_W];
endmodule

// File: rtl/aux_ctl_chk.sv
module aux_ctl_chk
  import aux_ctl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input sel_e        sel,
  input logic [7:0]  cfg_q,
  input logic [7:0]  aux1_q,
  input logic [2:0]  aux2_q,
  input logic [7:0]  mctl_q,
  input logic [31:0] sys_q,
  input logic        irq_o,
  input logic        shutdown_req,
  input logic        sysrst_req,
  input logic        halt_req
);
  // R4
  a_r4_clear_bit_never_stored: assert property (@(posedge clk) disable iff (!rst_n)
    !aux2_q[1]);

  // R4
  a_r4_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && sel == SEL_AUX2 && bus_wdata[1] && !soft_rst) |-> !irq_o);

  // R5
  a_r5_shutdown_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(bus_wr && sel == SEL_AUX2 && bus_wdata[0]));

  // R5
  a_r5_write_gives_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_AUX2 && bus_wdata[0]) |=> shutdown_req);

  // R6
  a_r6_halt_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(bus_wr && sel == SEL_PM));

  // R6
  a_r6_write_gives_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_PM) |=> halt_req);

  // R7
  a_r7_reset_req_loads_value: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_req |-> (sys_q == 32'h2));

  // R9
  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (cfg_q == 8'h0 && aux1_q == 8'h0 && aux2_q == 3'h0 && mctl_q == 8'h0));
endmodule

bind aux_ctl_regs aux_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst     (soft_rst),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .sel          (sel),
  .cfg_q        (cfg_q),
  .aux1_q       (aux1_q),
  .aux2_q       (aux2_q),
  .mctl_q       (mctl_q),
  .sys_q        (sys_q),
  .irq_o        (irq_o),
  .shutdown_req (shutdown_req),
  .sysrst_req   (sysrst_req),
  .halt_req     (halt_req)
);

// File: tb/sim_aux_ctl_regs.sv
module sim_aux_ctl_regs;
  localparam logic [27:0] A_CFG  = 28'h1800000;
  localparam logic [27:0] A_AUX1 = 28'h1900000;
  localparam logic [27:0] A_AUX2 = 28'h1910000;
  localparam logic [27:0] A_DIAG = 28'h1A00000;
  localparam logic [27:0] A_MCTL = 28'h1B00000;
  localparam logic [27:0] A_PM   = 28'hA000000;
  localparam logic [27:0] A_LED  = 28'h1600000;
  localparam logic [27:0] A_SYS  = 28'h1F00000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [27:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pwr_fail = 1'b0;
  logic irq_o;
  logic [15:0] led_o;
  logic shutdown_req, sysrst_req, halt_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  aux_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_fail(pwr_fail), .irq_o(irq_o), .led_o(led_o),
    .shutdown_req(shutdown_req), .sysrst_req(sysrst_req), .halt_req(halt_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [27:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [27:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [27:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulses_chk(input string req, input logic [2:0] exp);
    chk(req, {29'd0, halt_req, sysrst_req, shutdown_req}, {29'd0, exp});
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic all_zero(input string req);
    rd_chk(req, A_CFG, 0);  rd_chk(req, A_AUX1, 0); rd_chk(req, A_AUX2, 0);
    rd_chk(req, A_DIAG, 0); rd_chk(req, A_MCTL, 0); rd_chk(req, A_LED, 0);
    rd_chk(req, A_SYS, 0);
    chk(req, {31'd0, irq_o}, 0);
    chk(req, {16'd0, led_o}, 0);
    pulses_chk(req, 3'b000);
  endtask

  initial begin
    logic [31:0] v;
    por();
    // R10: power-on state
    all_zero("R10 por");

    // R1: byte registers, full value sweep with aliased low address bits
    for (int i = 0; i < 256; i++) begin
      logic [15:0] lo;
      lo = 16'((i * 97) & 16'hFFFF);
      wr(A_AUX1 | 28'(lo), 32'(i) | 32'hABCD_0000);
      rd_chk("R1 aux1", A_AUX1 | 28'(lo ^ 16'h5A5A), 32'(i));
      wr(A_DIAG | 28'(lo), 32'(255 - i));
      rd_chk("R1 diag", A_DIAG, 32'(255 - i));
      wr(A_MCTL, 32'(i ^ 8'h3C));
      rd_chk("R1 mctl", A_MCTL | 28'hFFFF, 32'(i ^ 8'h3C));
      wr(A_CFG, 32'(i));
      rd_chk("R1 cfg", A_CFG, 32'(i));
      chk("R2 irq without status", {31'd0, irq_o}, 0);
    end
    wr(A_CFG, 0);

    // R4/R5: second auxiliary register write sweep, no status set
    for (int i = 0; i < 8; i++) begin
      wr(A_AUX2, 32'(i));
      pulses_chk("R5 shutdown pulse", {2'b00, 1'(i & 1)});
      @(negedge clk);
      pulses_chk("R5 pulse one cycle", 3'b000);
      rd_chk("R4 aux2 write", A_AUX2, 32'(i & 1));
    end
    wr(A_AUX2, 0);

    // R2/R3: power-fail with enable set
    wr(A_CFG, 32'h08);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 two-flop latency", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R3 status after sync", {31'd0, irq_o}, 1);
    rd_chk("R3 status bit", A_AUX2, 32'h4);
    wr(A_AUX2, 32'h1);
    pulses_chk("R5 shutdown with status", 3'b001);
    rd_chk("R4 status kept", A_AUX2, 32'h5);
    chk("R2 irq kept", {31'd0, irq_o}, 1);
    wr(A_AUX2, 32'h2);
    rd_chk("R4 clear command", A_AUX2, 32'h0);
    chk("R4 irq cleared", {31'd0, irq_o}, 0);
    repeat (4) @(negedge clk);
    chk("R3 steady level no reassert", {31'd0, irq_o}, 0);
    pwr_fail = 1'b0; repeat (4) @(negedge clk);
    pwr_fail = 1'b1; repeat (4) @(negedge clk);
    rd_chk("R3 new edge sets status", A_AUX2, 32'h4);
    wr(A_CFG, 32'h00);
    chk("R2 enable off masks irq", {31'd0, irq_o}, 0);
    rd_chk("R2 status sticky", A_AUX2, 32'h4);
    wr(A_CFG, 32'h08);
    chk("R2 enable on restores irq", {31'd0, irq_o}, 1);
    pwr_fail = 1'b0; repeat (4) @(negedge clk);
    rd_chk("R3 fall clears status", A_AUX2, 32'h0);
    chk("R3 irq low", {31'd0, irq_o}, 0);
    wr(A_CFG, 32'h00);
    pwr_fail = 1'b1; repeat (4) @(negedge clk);
    rd_chk("R3 disabled no status", A_AUX2, 32'h0);
    pwr_fail = 1'b0; repeat (4) @(negedge clk);

    // R6: power management
    wr(A_PM | 28'h1234, 32'h0);
    pulses_chk("R6 halt pulse", 3'b100);
    @(negedge clk);
    pulses_chk("R6 halt one cycle", 3'b000);
    rd_chk("R6 read zero", A_PM, 0);

    // R7: system control
    wr(A_SYS, 32'hFFFF_FFFE);
    pulses_chk("R7 bit0 clear no pulse", 3'b000);
    rd_chk("R7 bit0 clear ignored", A_SYS, 0);
    wr(A_SYS | 28'h1, 32'h1);
    pulses_chk("R7 offset1 no pulse", 3'b000);
    rd_chk("R7 offset1 ignored", A_SYS, 0);
    wr(A_SYS, 32'h1);
    pulses_chk("R7 reset pulse", 3'b010);
    @(negedge clk);
    pulses_chk("R7 reset one cycle", 3'b000);
    rd_chk("R7 loaded value", A_SYS, 32'h2);
    rd_chk("R7 offset2 reads zero", A_SYS | 28'h2, 0);

    // R8: LED register sweep
    for (int i = 0; i < 64; i++) begin
      logic [15:0] pat;
      pat = 16'((i * 1031) ^ (i << 9));
      wr(A_LED, {16'hFFFF, pat});
      chk("R8 led drive", {16'd0, led_o}, {16'd0, pat});
      rd_chk("R8 led read", A_LED, {16'd0, pat});
    end
    rd_chk("R8 offset3 reads zero", A_LED | 28'h3, 0);
    wr(A_LED | 28'h1, 32'h0);
    chk("R8 offset1 write ignored", {31'd0, led_o == 16'd0}, 0);

    // R11: no read strobe, unmapped
    @(negedge clk);
    bus_addr = A_SYS; bus_rd = 1'b0;
    #2 chk("R11 idle rdata", bus_rdata, 0);
    rd_chk("R11 unmapped", 28'h1234560, 0);

    // R9: soft reset
    wr(A_CFG, 32'h5A); wr(A_AUX1, 32'h77); wr(A_AUX2, 32'h1);
    wr(A_DIAG, 32'h3C); wr(A_MCTL, 32'hC3); wr(A_LED, 32'hBEEF);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd_chk("R9 cfg cleared", A_CFG, 0);
    rd_chk("R9 aux1 cleared", A_AUX1, 0);
    rd_chk("R9 aux2 cleared", A_AUX2, 0);
    rd_chk("R9 mctl cleared", A_MCTL, 0);
    rd_chk("R9 diag kept", A_DIAG, 32'h3C);
    rd_chk("R9 sys kept", A_SYS, 32'h2);
    rd_chk("R9 led kept", A_LED, 32'hBEEF);

    // R10: power-on reset clears everything
    por();
    all_zero("R10 por again");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule